// File: doc/BRIEF.md
# Power-Up Memory Boot Sequencer

After the active-low reset is released, this block fills a processor's working memories during one fixed window of cycles. One copy engine reads a program boot ROM word by word and writes each word into program RAM. A second copy engine does the same from a parameter boot ROM into parameter RAM. Both engines run in parallel. A third engine writes zero into every word of the data memory in the same window. The window always lasts a fixed number of clock edges, whatever the clock frequency is. When the window ends, `boot_done` rises and stays high until the next reset.

The host control port sits in front of the register space. It is a valid/ready request channel followed by a one-beat read response. While the window is open, the block accepts every request with `host_ready` high and discards it. Nothing reaches the register side. A discarded read still returns one response with data zero and sets a sticky error flag. A discarded write returns no response and does not set the flag. Once `boot_done` is high, requests pass straight through to the register side, and back-pressure comes from `fwd_ready`. A host that sees `host_ready` low must hold its request stable until it is taken.

Each ROM has a read latency of one clock. The word for the address issued with `*_rom_en` high is presented on `*_rom_data` after the next edge. Each RAM or clear port writes on the clock edge that follows a cycle in which its write enable is high.

Top module: `mem_boot_seq`

## Requirements
- R1: After `rst_n` rises, `boot_done` stays low for the first BOOT_CYCLES (1024) rising clock edges. It is high after edge 1024 and stays high until `rst_n` falls again.
- R2: Program RAM is written once at every address 0 to 2^PROG_AW-1, in increasing order starting at 0. Each write carries the program ROM word read at that address.
- R3: Parameter RAM is written once at every address 0 to 2^PAR_AW-1, in increasing order starting at 0. Each write carries the parameter ROM word read at that address.
- R4: The data clear port writes once at every address 0 to 2^DATA_AW-1, in increasing order, with all-zero data.
- R5: No program, parameter or clear write is issued once `boot_done` is high.
- R6: While `boot_done` is low, `host_ready` is high and `fwd_valid` stays low for any host request.
- R7: A read (`host_valid`=1, `host_write`=0) presented while `boot_done` is low produces `rsp_valid`=1 with `rsp_rdata`=0 on the next cycle. It also sets `host_err`, which stays high until reset.
- R8: A write (`host_write`=1) presented while `boot_done` is low produces no response and leaves `host_err` unchanged.
- R9: While `boot_done` is high: `fwd_valid` equals `host_valid`, and `host_ready` equals `fwd_ready`. An accepted read returns `rsp_valid`=1 on the next cycle, carrying the `fwd_rdata` seen in the accept cycle.
- R10: Asserting `rst_n` low in the middle of the window aborts it. The next release starts a full new window, with all copies and clears restarting at address 0, and `host_err` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the window starts when it rises |
| boot_done | output | 1 | High once the boot window has ended |
| prog_rom_en | output | 1 | Program ROM read strobe |
| prog_rom_addr | output | PROG_AW | Program ROM read address |
| prog_rom_data | input | PROG_DW | Program ROM word, one cycle after the strobe |
| prog_ram_we | output | 1 | Program RAM write enable |
| prog_ram_addr | output | PROG_AW | Program RAM write address |
| prog_ram_wdata | output | PROG_DW | Program RAM write data |
| par_rom_en | output | 1 | Parameter ROM read strobe |
| par_rom_addr | output | PAR_AW | Parameter ROM read address |
| par_rom_data | input | PAR_DW | Parameter ROM word, one cycle after the strobe |
| par_ram_we | output | 1 | Parameter RAM write enable |
| par_ram_addr | output | PAR_AW | Parameter RAM write address |
| par_ram_wdata | output | PAR_DW | Parameter RAM write data |
| data_clr_we | output | 1 | Data memory clear write enable |
| data_clr_addr | output | DATA_AW | Data memory clear address |
| data_clr_wdata | output | DATA_DW | Data memory clear data (zero) |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Host register address |
| host_wdata | input | HOST_DW | Host write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | HOST_DW | Read response data |
| host_err | output | 1 | Sticky flag: a read arrived during the boot window |
| fwd_valid | output | 1 | Request valid toward the register side |
| fwd_ready | input | 1 | Register side accepts the request |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | HOST_AW | Forwarded address |
| fwd_wdata | output | HOST_DW | Forwarded write data |
| fwd_rdata | input | HOST_DW | Register-side read data, valid in the accept cycle |

## Verification
The end of the boot window and a host transaction can fall on the same clock edge. The bench forces a read in the cycle just before `boot_done` rises, and another in the cycle just after. The first read must be discarded, with a zero response and the error flag set. The second must be forwarded and must return register data, so the hand-over is judged at a one-cycle boundary. A reset in the middle of the window is also provoked while the copies are running. The later run must then restart every write sequence at address zero.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2
  } host_op_e;

  function automatic host_op_e decode_op(input logic vld, input logic wr);
    if (!vld)   return OP_IDLE;
    else if (wr) return OP_WR;
    else        return OP_RD;
  endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int unsigned BOOT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int unsigned CW = (BOOT_CYCLES > 1) ? $clog2(BOOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BOOT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == LAST) begin
        done <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: once raised, done holds until reset
  p_done_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R1: done rises only after the count reached its final value
  p_done_at_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cnt) == LAST);

endmodule

// File: rtl/rom_copy_engine.sv
module rom_copy_engine #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  output logic          rom_en,
  output logic [AW-1:0] rom_addr,
  input  logic [DW-1:0] rom_data,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata
);
  localparam int unsigned   DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

  logic [AW-1:0] rd_ptr;
  logic          issued_all;

  // read side: one address per cycle until the whole ROM was requested
  assign rom_en   = enable & ~issued_all;
  assign rom_addr = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      issued_all <= 1'b0;
    end else if (rom_en) begin
      rd_ptr <= rd_ptr + 1'b1;
      if (rd_ptr == LAST) issued_all <= 1'b1;
    end
  end

  // write side: trails the read by the ROM latency of one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_we   <= 1'b0;
      ram_addr <= '0;
    end else begin
      ram_we   <= rom_en;
      ram_addr <= rd_ptr;
    end
  end

  assign ram_wdata = rom_data;

  // R2, R3: writes start at address zero
  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we) |-> ram_addr == '0);

  // R2, R3: back-to-back writes step the address by one
  p_seq_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && $past(ram_we) |-> ram_addr == $past(ram_addr) + 1'b1);

  // R2: after the last address, no further write is issued
  p_stop_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && ram_addr == LAST |=> !ram_we);

endmodule

// File: rtl/mem_clear_engine.sv
module mem_clear_engine #(
  parameter int unsigned AW = 9,
  parameter int unsigned DW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  output logic          clr_we,
  output logic [AW-1:0] clr_addr,
  output logic [DW-1:0] clr_wdata
);
  localparam int unsigned   DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

  logic [AW-1:0] ptr;
  logic          swept;
  logic          step;

  assign step = enable & ~swept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      swept    <= 1'b0;
      clr_we   <= 1'b0;
      clr_addr <= '0;
    end else begin
      clr_we   <= step;
      clr_addr <= ptr;
      if (step) begin
        ptr <= ptr + 1'b1;
        if (ptr == LAST) swept <= 1'b1;
      end
    end
  end

  assign clr_wdata = '0;

  // R4: the sweep starts at address zero and climbs by one
  p_clr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_we) |-> clr_addr == '0);

  p_clr_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && $past(clr_we) |-> clr_addr == $past(clr_addr) + 1'b1);

endmodule

// File: rtl/host_gate.sv
module host_gate
  import boot_seq_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_write,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          host_err,
  output logic          fwd_valid,
  input  logic          fwd_ready,
  output logic          fwd_write,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_wdata,
  input  logic [DW-1:0] fwd_rdata
);
  host_op_e op;
  logic     take_rd;

  assign op = decode_op(host_valid, host_write);

  // during the window everything is swallowed; afterwards pass-through
  assign fwd_valid  = host_valid & ~busy;
  assign fwd_write  = host_write;
  assign fwd_addr   = host_addr;
  assign fwd_wdata  = host_wdata;
  assign host_ready = busy | fwd_ready;
  assign take_rd    = (op == OP_RD) & host_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      host_err  <= 1'b0;
    end else begin
      rsp_valid <= take_rd;
      if (take_rd) rsp_rdata <= busy ? '0 : fwd_rdata;
      if (busy && op == OP_RD) host_err <= 1'b1;
    end
  end

  // R7: a read during the window gets a zero reply and a raised flag
  p_busy_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && !host_write && busy |=> rsp_valid && rsp_rdata == '0 && host_err);

  // R7: flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |=> host_err);

  // R8: a write during the window is silent
  p_busy_write_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_write && busy && !host_err |=> !rsp_valid && !host_err);

  // R9: an accepted read after the window returns the register data
  p_fwd_read_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_ready && !fwd_write |=> rsp_valid && rsp_rdata == $past(fwd_rdata));

endmodule

// File: rtl/mem_boot_seq.sv
module mem_boot_seq #(
  parameter int unsigned BOOT_CYCLES = 1024,
  parameter int unsigned PROG_AW     = 9,
  parameter int unsigned PROG_DW     = 24,
  parameter int unsigned PAR_AW      = 8,
  parameter int unsigned PAR_DW      = 26,
  parameter int unsigned DATA_AW     = 9,
  parameter int unsigned DATA_DW     = 26,
  parameter int unsigned HOST_AW     = 10,
  parameter int unsigned HOST_DW     = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               boot_done,
  output logic               prog_rom_en,
  output logic [PROG_AW-1:0] prog_rom_addr,
  input  logic [PROG_DW-1:0] prog_rom_data,
  output logic               prog_ram_we,
  output logic [PROG_AW-1:0] prog_ram_addr,
  output logic [PROG_DW-1:0] prog_ram_wdata,
  output logic               par_rom_en,
  output logic [PAR_AW-1:0]  par_rom_addr,
  input  logic [PAR_DW-1:0]  par_rom_data,
  output logic               par_ram_we,
  output logic [PAR_AW-1:0]  par_ram_addr,
  output logic [PAR_DW-1:0]  par_ram_wdata,
  output logic               data_clr_we,
  output logic [DATA_AW-1:0] data_clr_addr,
  output logic [DATA_DW-1:0] data_clr_wdata,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic               host_write,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic               rsp_valid,
  output logic [HOST_DW-1:0] rsp_rdata,
  output logic               host_err,
  output logic               fwd_valid,
  input  logic               fwd_ready,
  output logic               fwd_write,
  output logic [HOST_AW-1:0] fwd_addr,
  output logic [HOST_DW-1:0] fwd_wdata,
  input  logic [HOST_DW-1:0] fwd_rdata
);
  // each sweep needs its depth plus one cycle of ROM latency inside the window
  localparam int unsigned PROG_DEPTH = 1 << PROG_AW;
  localparam int unsigned PAR_DEPTH  = 1 << PAR_AW;
  localparam int unsigned DATA_DEPTH = 1 << DATA_AW;

  logic busy;

  boot_timer #(.BOOT_CYCLES(BOOT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (boot_done)
  );

  assign busy = ~boot_done;

  rom_copy_engine #(.AW(PROG_AW), .DW(PROG_DW)) u_prog_copy (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (busy),
    .rom_en    (prog_rom_en),
    .rom_addr  (prog_rom_addr),
    .rom_data  (prog_rom_data),
    .ram_we    (prog_ram_we),
    .ram_addr  (prog_ram_addr),
    .ram_wdata (prog_ram_wdata)
  );

  rom_copy_engine #(.AW(PAR_AW), .DW(PAR_DW)) u_par_copy (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (busy),
    .rom_en    (par_rom_en),
    .rom_addr  (par_rom_addr),
    .rom_data  (par_rom_data),
    .ram_we    (par_ram_we),
    .ram_addr  (par_ram_addr),
    .ram_wdata (par_ram_wdata)
  );

  mem_clear_engine #(.AW(DATA_AW), .DW(DATA_DW)) u_data_clr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (busy),
    .clr_we    (data_clr_we),
    .clr_addr  (data_clr_addr),
    .clr_wdata (data_clr_wdata)
  );

  host_gate #(.AW(HOST_AW), .DW(HOST_DW)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .host_write (host_write),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .host_err   (host_err),
    .fwd_valid  (fwd_valid),
    .fwd_ready  (fwd_ready),
    .fwd_write  (fwd_write),
    .fwd_addr   (fwd_addr),
    .fwd_wdata  (fwd_wdata),
    .fwd_rdata  (fwd_rdata)
  );

  // parameter sanity: every sweep must finish inside the window
  initial begin
    if (PROG_DEPTH + 1 > BOOT_CYCLES || PAR_DEPTH + 1 > BOOT_CYCLES ||
        DATA_DEPTH + 1 > BOOT_CYCLES)
      $display("mem_boot_seq: memory depth exceeds boot window");
  end

  // R5: no memory write leaks out after the window closes
  p_no_late_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ram_we || par_ram_we || data_clr_we) |-> !boot_done);

  // R6: nothing reaches the register side during the window
  p_no_fwd_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> !fwd_valid && host_ready);

endmodule

// File: tb/mem_boot_seq_tb.sv
`timescale 1ns/1ps
module mem_boot_seq_tb;
  localparam int BOOT = 1024;
  localparam int PAW = 9, PDW = 24, QAW = 8, QDW = 26, DAW = 9, DDW = 26;
  localparam int HAW = 10, HDW = 26;
  localparam int PDEP = 1 << PAW, QDEP = 1 << QAW, DDEP = 1 << DAW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic boot_done;
  logic prog_rom_en, prog_ram_we, par_rom_en, par_ram_we, data_clr_we;
  logic [PAW-1:0] prog_rom_addr, prog_ram_addr;
  logic [PDW-1:0] prog_rom_data, prog_ram_wdata;
  logic [QAW-1:0] par_rom_addr, par_ram_addr;
  logic [QDW-1:0] par_rom_data, par_ram_wdata;
  logic [DAW-1:0] data_clr_addr;
  logic [DDW-1:0] data_clr_wdata;
  logic host_valid = 0, host_ready, host_write = 0;
  logic [HAW-1:0] host_addr = '0;
  logic [HDW-1:0] host_wdata = '0;
  logic rsp_valid, host_err, fwd_valid, fwd_ready = 1'b1, fwd_write;
  logic [HDW-1:0] rsp_rdata, fwd_wdata, fwd_rdata;
  logic [HAW-1:0] fwd_addr;

  int vecs = 0, errs = 0;
  bit finished = 0;

  function automatic logic [PDW-1:0] prog_word(int i);
    return PDW'((i * 40503) ^ 24'h5A3C1 ^ (i << 13));
  endfunction
  function automatic logic [QDW-1:0] par_word(int i);
    return QDW'((i * 2654435) ^ 26'h15A5A5A);
  endfunction
  function automatic logic [HDW-1:0] reg_word(int a);
    return HDW'((a * 977) ^ 26'h2C0FFEE);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ROMs with one cycle read latency; register-side responder
  always @(posedge clk) if (prog_rom_en) prog_rom_data <= prog_word(int'(prog_rom_addr));
  always @(posedge clk) if (par_rom_en)  par_rom_data  <= par_word(int'(par_rom_addr));
  assign fwd_rdata = reg_word(int'(fwd_addr));

  mem_boot_seq u_dut (.*);

  // memory models and write-order monitors
  logic [PDW-1:0] pmem [PDEP];
  logic [QDW-1:0] qmem [QDEP];
  logic [DDW-1:0] dmem [DDEP];
  int pcnt [PDEP];
  int qcnt [QDEP];
  int dcnt [DDEP];
  int pnext = 0, qnext = 0, dnext = 0;

  always @(posedge clk) begin
    if (prog_ram_we) begin
      chk(int'(prog_ram_addr) == pnext && !boot_done, "R2 order", prog_ram_addr, pnext);
      pmem[prog_ram_addr] = prog_ram_wdata;
      pcnt[prog_ram_addr]++;
      pnext++;
    end
    if (par_ram_we) begin
      chk(int'(par_ram_addr) == qnext && !boot_done, "R3 order", par_ram_addr, qnext);
      qmem[par_ram_addr] = par_ram_wdata;
      qcnt[par_ram_addr]++;
      qnext++;
    end
    if (data_clr_we) begin
      chk(int'(data_clr_addr) == dnext && !boot_done, "R4 order", data_clr_addr, dnext);
      dmem[data_clr_addr] = data_clr_wdata;
      dcnt[data_clr_addr]++;
      dnext++;
    end
  end

  bit exp_err = 0;

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    host_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(boot_done == 1'b0, "R1 reset done", boot_done, 0);
    chk(!prog_ram_we && !par_ram_we && !data_clr_we, "R5 reset writes", 0, 0);
    chk(host_err == 1'b0, "R10 reset err", host_err, 0);
    chk(rsp_valid == 1'b0, "R7 reset rsp", rsp_valid, 0);
    for (int i = 0; i < PDEP; i++) begin pcnt[i] = 0; pmem[i] = '1; end
    for (int i = 0; i < QDEP; i++) begin qcnt[i] = 0; qmem[i] = '1; end
    for (int i = 0; i < DDEP; i++) begin dcnt[i] = 0; dmem[i] = '1; end
    pnext = 0; qnext = 0; dnext = 0;
    exp_err = 0;
    rst_n = 1'b1;
  endtask

  // run ncyc cycles after release; k counts edges since release
  task automatic run_window(int ncyc);
    bit exp_rsp = 0, held = 0;
    logic [HDW-1:0] exp_data = '0;
    for (int k = 0; k < ncyc; k++) begin
      bit busy_now = (k < BOOT);
      if (k > 0) begin
        chk(rsp_valid == exp_rsp, busy_now || k == BOOT ? "R7 rsp valid" : "R9 rsp valid",
            rsp_valid, exp_rsp);
        if (exp_rsp)
          chk(rsp_rdata == exp_data, k <= BOOT ? "R7 rsp zero" : "R9 rsp data",
              rsp_rdata, exp_data);
        chk(host_err == exp_err, "R8 err flag", host_err, exp_err);
      end
      chk(boot_done == !busy_now, "R1 done timing", boot_done, !busy_now);
      if (!held) begin
        host_valid = $urandom_range(0, 1);
        host_write = $urandom_range(0, 1);
        host_addr  = HAW'($urandom);
        host_wdata = HDW'($urandom);
        if (k < 10) host_write = 1'b1;               // R8 directed writes
        if (k == BOOT - 1 || k == BOOT) begin host_valid = 1; host_write = 0; end
      end
      fwd_ready = ($urandom_range(0, 3) != 0) || k == BOOT;
      #1;
      if (busy_now) begin
        chk(!fwd_valid && host_ready, "R6 gated", {fwd_valid, host_ready}, 2'b01);
        exp_rsp  = host_valid && !host_write;
        exp_data = '0;
        if (exp_rsp) exp_err = 1;
        held = 0;
      end else begin
        chk(fwd_valid == host_valid && host_ready == fwd_ready, "R9 pass",
            {fwd_valid, host_ready}, {host_valid, fwd_ready});
        exp_rsp  = host_valid && !host_write && fwd_ready;
        exp_data = reg_word(int'(host_addr));
        held = host_valid && !fwd_ready;
      end
      @(negedge clk);
    end
    host_valid = 1'b0;
  endtask

  task automatic check_contents();
    for (int i = 0; i < PDEP; i++)
      chk(pcnt[i] == 1 && pmem[i] == prog_word(i), "R2 content", pmem[i], prog_word(i));
    for (int i = 0; i < QDEP; i++)
      chk(qcnt[i] == 1 && qmem[i] == par_word(i), "R3 content", qmem[i], par_word(i));
    for (int i = 0; i < DDEP; i++)
      chk(dcnt[i] == 1 && dmem[i] == '0, "R4 clear", dmem[i], 0);
  endtask

  initial begin
    void'($urandom(32'h1D54));
    do_reset();
    run_window(300);           // aborted mid-window
    do_reset();                // R10: full restart expected
    run_window(BOOT + 80);
    check_contents();
    chk(boot_done == 1'b1, "R1 hold", boot_done, 1);
    chk(!prog_ram_we && !par_ram_we && !data_clr_we, "R5 quiet", 0, 0);
    do_reset();
    run_window(BOOT + 20);
    check_contents();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vecs++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule